// File: doc/BRIEF.md
# Linear Systolic Outer-Product Matrix Multiplier

This block forms one output tile of C = A·B, where A is N×K, B is K×M and C is N×M, on a one-dimensional chain of processing elements. Each processing element owns one row of the output tile, so a tile covers `P` rows and up to `V × MB_MAX` columns. For every k step the block first shifts one column of A into the chain, so that each element holds its own scalar. It then takes the matching row of B as a series of vectors that are `V` lanes wide. Each vector moves down the chain one hop per cycle, and every element combines its held scalar with each lane and folds the result into a local accumulator bank. The chain performs 2·P·V operations per cycle while vectors are streaming.

The combine and fold operators are chosen per tile. Choosing multiply and add gives the ordinary product. Choosing add and minimum gives the min-plus distance product. The reduction depth K and the number of column vectors per row can be fixed when the block is built, or taken from inputs at the start of each tile. After the last k step the accumulators are emitted row by row on a valid/ready output stream, which honours backpressure. The next tile is not accepted until the whole tile has been emitted.

Top module: `sysmm_top`

## Requirements
- R1: After reset `a_ready` is 1, `b_ready` is 0 and `c_valid` is 0.
- R2: Each k step accepts exactly P beats on the A stream, then lowers `a_ready` and raises `b_ready`. The first A beat of a step lands in the last processing element and the P-th lands in element 0, so A values are sent for rows P-1 down to 0.
- R3: After the A beats, each k step accepts exactly `beats` B vectors. Lane j (bits j·DW upward) of B beat c carries B[k][c·V+j].
- R4: With `op_sel`=0, output element C[i][n] is the sum over k of A[i][k]·B[k][n], using signed operands and modulo-2^AW accumulation.
- R5: With `op_sel`=1, output element C[i][n] is the minimum over k of A[i][k]+B[k][n], using signed values.
- R6: A tile yields P·`beats` output beats. They come in row order from 0 to P-1, and within a row in column-beat order. Lane j (bits j·AW upward) of beat c of row i holds C[i][c·V+j]. `c_last` is 1 only on the final beat.
- R7: While `c_valid` is 1 and `c_ready` is 0, `c_data` and `c_last` hold their values, and no beat is lost.
- R8: No input is accepted while the output is being emitted: at most one of `a_ready`, `b_ready` and `c_valid` is 1. `a_ready` returns to 1 after the final output handshake.
- R9: `cfg_k` (1..K_MAX) and `cfg_beats` (1..MB_MAX) are sampled on the first A beat of a tile. Changing them later in the tile has no effect on that tile.
- R10: Each tile's results depend only on that tile's inputs, as if every accumulator started at the fold identity (0 for add, the largest signed value for minimum).
- R11: `op_sel` is sampled on the first A beat of a tile. Changing it later in the tile has no effect on that tile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 1 | Operator set: 0 multiply/add, 1 add/minimum |
| cfg_k | input | $clog2(K_MAX+1) | Reduction depth for the tile |
| cfg_beats | input | $clog2(MB_MAX+1) | Column vectors per output row |
| a_valid | input | 1 | A beat valid |
| a_ready | output | 1 | A beat accepted |
| a_data | input | DW | One signed A element |
| b_valid | input | 1 | B vector valid |
| b_ready | output | 1 | B vector accepted |
| b_data | input | V·DW | V signed B elements |
| c_valid | output | 1 | Output beat valid |
| c_ready | input | 1 | Output beat taken |
| c_data | output | V·AW | V signed results |
| c_last | output | 1 | Final beat of the tile |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up. They also assume that `cfg_k` and `cfg_beats` lie within their legal ranges when a tile's first A beat is accepted, and that the source offers exactly the beat counts that the tile's sizes call for. The stimulus only ever programs depths from 1 to K_MAX and widths from 1 to MB_MAX. It sends exactly P A beats and `beats` B vectors per k step, and it deliberately changes the sampled controls only after a tile has started. Operand values are kept to 8-bit signed numbers, so that sums and minima are exact in 32 bits.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic {
    OP_MULADD  = 1'b0,
    OP_MINPLUS = 1'b1
  } mm_op_e;

  typedef enum logic [1:0] {
    ST_LOADA   = 2'd0,
    ST_STREAMB = 2'd1,
    ST_FLUSH   = 2'd2,
    ST_DRAIN   = 2'd3
  } mm_state_e;
endpackage

// File: rtl/mm_pe.sv
module mm_pe
  import mm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 32,
  parameter int V     = 4,
  parameter int DEPTH = 2,
  parameter int CW    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  mm_op_e            op,
  input  logic              a_shift,
  input  logic [DW-1:0]     a_in,
  output logic [DW-1:0]     a_out,
  input  logic              in_vld,
  input  logic              in_first,
  input  logic [CW-1:0]     in_col,
  input  logic [V*DW-1:0]   in_b,
  output logic              out_vld,
  output logic              out_first,
  output logic [CW-1:0]     out_col,
  output logic [V*DW-1:0]   out_b,
  input  logic [CW-1:0]     rd_addr,
  output logic [V*AW-1:0]   rd_data
);
  logic [DW-1:0]            a_q;
  logic [V*AW-1:0]          bank [DEPTH];
  logic [V*AW-1:0]          old_word;
  logic [V*AW-1:0]          new_word;
  logic signed [AW-1:0]     a_ext;
  logic signed [AW-1:0]     b_ext  [V];
  logic signed [AW-1:0]     comb_v [V];
  logic signed [AW-1:0]     base_v [V];
  logic signed [AW-1:0]     ident;

  assign a_out   = a_q;
  assign rd_data = bank[rd_addr];
  assign old_word = bank[in_col];
  assign a_ext = {{(AW-DW){a_q[DW-1]}}, a_q};
  // fold identity: zero for sum, largest signed value for minimum
  assign ident = (op == OP_MULADD) ? '0 : {1'b0, {(AW-1){1'b1}}};

  always_comb begin
    for (int j = 0; j < V; j++) begin
      b_ext[j]  = {{(AW-DW){in_b[j*DW+DW-1]}}, in_b[j*DW +: DW]};
      comb_v[j] = (op == OP_MULADD) ? a_ext * b_ext[j] : a_ext + b_ext[j];
      base_v[j] = in_first ? ident : $signed(old_word[j*AW +: AW]);
      if (op == OP_MULADD)
        new_word[j*AW +: AW] = base_v[j] + comb_v[j];
      else
        new_word[j*AW +: AW] = (comb_v[j] < base_v[j]) ? comb_v[j] : base_v[j];
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) bank[in_col] <= new_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      out_vld   <= 1'b0;
      out_first <= 1'b0;
      out_col   <= '0;
      out_b     <= '0;
    end else begin
      if (a_shift) a_q <= a_in;
      out_vld   <= in_vld;
      out_first <= in_first;
      out_col   <= in_col;
      out_b     <= in_b;
    end
  end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int P         = 4,
  parameter int V         = 4,
  parameter int DW        = 8,
  parameter int AW        = 32,
  parameter int K_MAX     = 8,
  parameter int MB_MAX    = 2,
  parameter bit DYN_SIZES = 1'b1,
  parameter int KW        = 4,
  parameter int BW        = 2,
  parameter int CW        = 1,
  parameter int PW        = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_sel,
  input  logic [KW-1:0]   cfg_k,
  input  logic [BW-1:0]   cfg_beats,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic            b_valid,
  output logic            b_ready,
  input  logic [V*DW-1:0] b_data,
  output mm_op_e          op_q,
  output logic            iss_vld,
  output logic            iss_first,
  output logic [CW-1:0]   iss_col,
  output logic [V*DW-1:0] iss_b,
  output logic [PW-1:0]   rd_pe,
  output logic [CW-1:0]   rd_addr,
  input  logic [V*AW-1:0] rd_data,
  output logic            c_valid,
  input  logic            c_ready,
  output logic [V*AW-1:0] c_data,
  output logic            c_last
);
  mm_state_e     state;
  logic [PW-1:0] a_cnt, fl_cnt, dr_pe;
  logic [BW-1:0] b_cnt, dr_beat, mb_q, mb_src;
  logic [KW-1:0] k_cnt, k_q, k_src;
  logic          dr_done, dr_is_last;

  generate
    if (DYN_SIZES) begin : g_dyn
      assign k_src  = cfg_k;
      assign mb_src = cfg_beats;
    end else begin : g_fix
      assign k_src  = KW'(K_MAX);
      assign mb_src = BW'(MB_MAX);
    end
  endgenerate

  assign a_ready    = (state == ST_LOADA);
  assign b_ready    = (state == ST_STREAMB);
  assign rd_pe      = dr_pe;
  assign rd_addr    = CW'(dr_beat);
  assign dr_is_last = (dr_pe == PW'(P-1)) && (dr_beat == mb_q - BW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOADA;
      a_cnt <= '0; b_cnt <= '0; fl_cnt <= '0; k_cnt <= '0;
      op_q <= OP_MULADD; k_q <= KW'(1); mb_q <= BW'(1);
      iss_vld <= 1'b0; iss_first <= 1'b0; iss_col <= '0; iss_b <= '0;
      dr_pe <= '0; dr_beat <= '0; dr_done <= 1'b0;
      c_valid <= 1'b0; c_last <= 1'b0; c_data <= '0;
    end else begin
      iss_vld <= 1'b0;
      case (state)
        ST_LOADA: if (a_valid) begin
          if (k_cnt == '0 && a_cnt == '0) begin
            op_q <= mm_op_e'(op_sel);
            k_q  <= k_src;
            mb_q <= mb_src;
          end
          if (a_cnt == PW'(P-1)) begin
            a_cnt <= '0;
            state <= ST_STREAMB;
          end else a_cnt <= a_cnt + 1'b1;
        end
        ST_STREAMB: if (b_valid) begin
          iss_vld   <= 1'b1;
          iss_first <= (k_cnt == '0);
          iss_col   <= CW'(b_cnt);
          iss_b     <= b_data;
          if (b_cnt == mb_q - BW'(1)) begin
            b_cnt <= '0;
            state <= ST_FLUSH;
          end else b_cnt <= b_cnt + 1'b1;
        end
        ST_FLUSH: begin
          // wait until the last vector has passed the final element
          if (fl_cnt == PW'(P-1)) begin
            fl_cnt <= '0;
            if (k_cnt == k_q - KW'(1)) begin
              k_cnt <= '0;
              state <= ST_DRAIN;
            end else begin
              k_cnt <= k_cnt + 1'b1;
              state <= ST_LOADA;
            end
          end else fl_cnt <= fl_cnt + 1'b1;
        end
        ST_DRAIN: if (!c_valid || c_ready) begin
          if (!dr_done) begin
            c_valid <= 1'b1;
            c_data  <= rd_data;
            c_last  <= dr_is_last;
            if (dr_is_last) dr_done <= 1'b1;
            else if (dr_beat == mb_q - BW'(1)) begin
              dr_beat <= '0;
              dr_pe   <= dr_pe + 1'b1;
            end else dr_beat <= dr_beat + 1'b1;
          end else begin
            c_valid <= 1'b0;
            c_last  <= 1'b0;
            dr_done <= 1'b0;
            dr_pe   <= '0;
            dr_beat <= '0;
            state   <= ST_LOADA;
          end
        end
        default: state <= ST_LOADA;
      endcase
    end
  end
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
  import mm_pkg::*;
#(
  parameter int P         = 4,
  parameter int V         = 4,
  parameter int DW        = 8,
  parameter int AW        = 32,
  parameter int K_MAX     = 8,
  parameter int MB_MAX    = 2,
  parameter bit DYN_SIZES = 1'b1,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int BW = $clog2(MB_MAX + 1),
  localparam int CW = (MB_MAX > 1) ? $clog2(MB_MAX) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_sel,
  input  logic [KW-1:0]   cfg_k,
  input  logic [BW-1:0]   cfg_beats,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic [DW-1:0]   a_data,
  input  logic            b_valid,
  output logic            b_ready,
  input  logic [V*DW-1:0] b_data,
  output logic            c_valid,
  input  logic            c_ready,
  output logic [V*AW-1:0] c_data,
  output logic            c_last
);
  mm_op_e          op_q;
  logic            a_shift;
  logic [DW-1:0]   a_ch     [P+1];
  logic            vld_ch   [P+1];
  logic            first_ch [P+1];
  logic [CW-1:0]   col_ch   [P+1];
  logic [V*DW-1:0] b_ch     [P+1];
  logic [V*AW-1:0] rd_all   [P];
  logic [PW-1:0]   rd_pe;
  logic [CW-1:0]   rd_addr;

  assign a_shift = a_valid && a_ready;
  assign a_ch[0] = a_data;

  mm_ctrl #(.P(P), .V(V), .DW(DW), .AW(AW), .K_MAX(K_MAX), .MB_MAX(MB_MAX),
            .DYN_SIZES(DYN_SIZES), .KW(KW), .BW(BW), .CW(CW), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .op_sel(op_sel), .cfg_k(cfg_k), .cfg_beats(cfg_beats),
    .a_valid(a_valid), .a_ready(a_ready), .b_valid(b_valid), .b_ready(b_ready),
    .b_data(b_data), .op_q(op_q), .iss_vld(vld_ch[0]), .iss_first(first_ch[0]),
    .iss_col(col_ch[0]), .iss_b(b_ch[0]), .rd_pe(rd_pe), .rd_addr(rd_addr),
    .rd_data(rd_all[rd_pe]), .c_valid(c_valid), .c_ready(c_ready),
    .c_data(c_data), .c_last(c_last)
  );

  generate
    for (genvar i = 0; i < P; i++) begin : g_pe
      mm_pe #(.DW(DW), .AW(AW), .V(V), .DEPTH(MB_MAX), .CW(CW)) u_pe (
        .clk(clk), .rst(rst), .op(op_q),
        .a_shift(a_shift), .a_in(a_ch[i]), .a_out(a_ch[i+1]),
        .in_vld(vld_ch[i]), .in_first(first_ch[i]), .in_col(col_ch[i]), .in_b(b_ch[i]),
        .out_vld(vld_ch[i+1]), .out_first(first_ch[i+1]), .out_col(col_ch[i+1]),
        .out_b(b_ch[i+1]), .rd_addr(rd_addr), .rd_data(rd_all[i])
      );
    end
  endgenerate
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
  parameter int P  = 4,
  parameter int V  = 4,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            a_valid,
  input logic            a_ready,
  input logic            b_ready,
  input logic            c_valid,
  input logic            c_ready,
  input logic [V*AW-1:0] c_data,
  input logic            c_last
);
  logic [15:0] a_hs_cnt;
  logic [15:0] c_hs_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hs_cnt <= '0;
      c_hs_cnt <= '0;
    end else begin
      if (b_ready) a_hs_cnt <= '0;
      else if (a_valid && a_ready) a_hs_cnt <= a_hs_cnt + 1'b1;
      if (c_valid && c_ready) c_hs_cnt <= c_last ? '0 : c_hs_cnt + 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_ready && !b_ready && !c_valid));

  assert_a_count_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(b_ready) |-> (a_hs_cnt == 16'(P)));

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
    c_last |-> c_valid);

  assert_beats_R6: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_ready && c_last) |-> (((c_hs_cnt + 16'd1) % 16'(P)) == 16'd0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_data) && $stable(c_last)));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_ready, b_ready, c_valid}));
endmodule

bind sysmm_top sysmm_chk #(.P(P), .V(V), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .a_valid(a_valid), .a_ready(a_ready), .b_ready(b_ready),
  .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data), .c_last(c_last)
);

// File: tb/sim_sysmm_top.sv
`timescale 1ns/1ps
module sim_sysmm_top;
  localparam int P = 4, V = 4, DW = 8, AW = 32, K_MAX = 8, MB_MAX = 2;
  localparam int KW = $clog2(K_MAX + 1), BW = $clog2(MB_MAX + 1);
  localparam int COLS = V * MB_MAX;

  logic clk = 1'b0, rst = 1'b1, op_sel = 1'b0;
  logic [KW-1:0] cfg_k = '0;
  logic [BW-1:0] cfg_beats = '0;
  logic a_valid = 1'b0, b_valid = 1'b0, c_ready = 1'b0;
  logic [DW-1:0] a_data = '0;
  logic [V*DW-1:0] b_data = '0;
  logic a_ready, b_ready, c_valid, c_last;
  logic [V*AW-1:0] c_data;

  int checks = 0, errors = 0;
  int mat_a [P][K_MAX];
  int mat_b [K_MAX][COLS];
  int exp_c [P][COLS];

  always #2.5 clk = ~clk;

  sysmm_top #(.P(P), .V(V), .DW(DW), .AW(AW), .K_MAX(K_MAX), .MB_MAX(MB_MAX)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .cfg_k(cfg_k), .cfg_beats(cfg_beats),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data), .c_last(c_last));

  task automatic check(input bit ok, input string req, input logic [V*AW-1:0] act,
                       input logic [V*AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sbyte(input int x);
    logic [7:0] t;
    t = 8'(x);
    return int'($signed(t));
  endfunction

  task automatic fill(input int lo, input int hi, input int k, input int mb);
    for (int i = 0; i < P; i++)
      for (int kk = 0; kk < k; kk++) mat_a[i][kk] = lo + int'($urandom_range(0, hi - lo));
    for (int kk = 0; kk < k; kk++)
      for (int n = 0; n < mb * V; n++) mat_b[kk][n] = lo + int'($urandom_range(0, hi - lo));
  endtask

  task automatic compute(input bit op, input int k, input int mb);
    for (int i = 0; i < P; i++)
      for (int n = 0; n < mb * V; n++) begin
        int acc;
        acc = op ? 32'sh7fffffff : 0;
        for (int kk = 0; kk < k; kk++) begin
          int t;
          t = op ? mat_a[i][kk] + mat_b[kk][n] : mat_a[i][kk] * mat_b[kk][n];
          if (op) acc = (t < acc) ? t : acc;
          else acc = acc + t;
        end
        exp_c[i][n] = acc;
      end
  endtask

  // drives one tile; chg alters op_sel/cfg after the first A beat (R9, R11)
  task automatic run_tile(input bit op, input int k, input int mb, input bit stall,
                          input bit chg, input string tag);
    int total, idx, cyc;
    compute(op, k, mb);
    op_sel = op; cfg_k = KW'(k); cfg_beats = BW'(mb);
    for (int kk = 0; kk < k; kk++) begin
      for (int r = 0; r < P; r++) begin
        @(negedge clk);
        a_valid = 1'b1; a_data = DW'(mat_a[P-1-r][kk]);
        while (!a_ready) @(negedge clk);
        @(negedge clk);
        a_valid = 1'b0;
        if (chg && kk == 0 && r == 0) begin
          op_sel = ~op; cfg_k = KW'((k < 7) ? 7 : 1); cfg_beats = BW'((mb == 1) ? 2 : 1);
        end
      end
      check(b_ready && !a_ready, "R2 ready swap after P A beats",
            {b_ready, a_ready}, 2'b10);
      for (int c = 0; c < mb; c++) begin
        logic [V*DW-1:0] v;
        for (int j = 0; j < V; j++) v[j*DW +: DW] = DW'(mat_b[kk][c*V + j]);
        @(negedge clk);
        b_valid = 1'b1; b_data = v;
        while (!b_ready) @(negedge clk);
        @(negedge clk);
        b_valid = 1'b0;
      end
    end
    total = P * mb; idx = 0; cyc = 0;
    while (idx < total) begin
      logic [V*AW-1:0] ev;
      @(negedge clk);
      c_ready = stall ? (cyc % 3 == 2) : 1'b1;
      cyc++;
      for (int j = 0; j < V; j++) ev[j*AW +: AW] = AW'(exp_c[idx / mb][(idx % mb) * V + j]);
      if (c_valid) begin
        check(!a_ready && !b_ready, "R8 inputs closed during drain",
              {a_ready, b_ready}, '0);
        if (c_ready) begin
          check(c_data == ev, {tag, " R6 beat data"}, c_data, ev);
          check(c_last == (idx == total - 1), "R6 last flag", c_last, (idx == total - 1));
          idx++;
        end else begin
          check(c_data == ev, "R7 held under backpressure", c_data, ev);
        end
      end
    end
    @(negedge clk);
    c_ready = 1'b0;
    check(a_ready && !c_valid, "R8 accepts next tile after drain", {a_ready, c_valid}, 2'b10);
  endtask

  task automatic t_reset;
    check(a_ready == 1'b1, "R1 a_ready after reset", a_ready, 1);
    check(b_ready == 1'b0, "R1 b_ready after reset", b_ready, 0);
    check(c_valid == 1'b0, "R1 c_valid after reset", c_valid, 0);
  endtask

  task automatic t_muladd;   // R3, R4
    fill(-128, 127, 3, 2);
    run_tile(1'b0, 3, 2, 1'b0, 1'b0, "R4 mul-add");
    fill(-5, 5, K_MAX, 2);
    run_tile(1'b0, K_MAX, 2, 1'b0, 1'b0, "R3 R4 full depth");
  endtask

  task automatic t_minplus;  // R5
    fill(-128, 127, 4, 2);
    run_tile(1'b1, 4, 2, 1'b0, 1'b0, "R5 min-plus");
    fill(100, 127, 1, 1);
    run_tile(1'b1, 1, 1, 1'b0, 1'b0, "R5 single step");
  endtask

  task automatic t_backpressure;  // R7
    fill(-20, 20, 2, 2);
    run_tile(1'b0, 2, 2, 1'b1, 1'b0, "R7 stalled drain");
  endtask

  task automatic t_runtime_cfg;   // R9, R11
    fill(-30, 30, 2, 1);
    run_tile(1'b0, 2, 1, 1'b0, 1'b1, "R9 R11 late cfg change");
    fill(-30, 30, 5, 2);
    run_tile(1'b1, 5, 2, 1'b1, 1'b1, "R9 R11 late cfg change min");
  endtask

  task automatic t_restart;       // R10
    fill(100, 127, 3, 2);
    run_tile(1'b0, 3, 2, 1'b0, 1'b0, "R10 first tile");
    fill(-3, 3, 1, 2);
    run_tile(1'b0, 1, 2, 1'b0, 1'b0, "R10 fresh sum");
    fill(-128, -100, 2, 2);
    run_tile(1'b1, 2, 2, 1'b0, 1'b0, "R10 fresh min");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_muladd();
    t_minplus();
    t_backpressure();
    t_runtime_cfg();
    t_restart();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule